// File: doc/BRIEF.md
# Multi-Queue Hardware FIFO Manager

This block keeps 64 independent hardware queues in one shared on-chip RAM and serves them over a simple synchronous register bus. Every queue owns a fixed region of 16 entries, each entry being one to four 32-bit words. The processor moves data by touching a queue's four-word access window. Writing the window pushes an entry and reading it pops one. No storage lives at those addresses.

Per-queue fill state is summarised in four flags packed into readable status words. Sticky overflow and underflow bits record pushes into a full queue and pops from an empty one. The status words are shadow copies. Software can write them to change what it reads back, but such writes never touch fill counts or data. The shadow is refreshed from the live flags whenever any queue's count moves. Read data appears on the cycle after the read strobe.

Top module: `hwQueueMgr`

## Requirements
- R1: After reset, every status word reads 0x33333333, all sticky overflow and underflow words read 0, every queue's entry size reads 0 (one word), and the read data output is 0.
- R2: Word x (0..3) of queue q's window sits at byte address 16*q + 4*x. A write to word size-1 commits the entry and a read of word size-1 pops it. Entries leave each queue in the order they were committed. Read data is valid one cycle after the read strobe.
- R3: The size register of queue q sits at 0x500 + 4*q, with bits [1:0] holding size-1. A window write to a word at or above the size is ignored. A window read there returns 0 and pops nothing.
- R4: Each queue holds at most 16 entries. A push to a full queue is dropped and sets that queue's overflow bit, and the stored entries stay intact.
- R5: Popping an empty queue returns 0 on every word and sets that queue's underflow bit.
- R6: Status word k at 0x400 + 4*k holds queues 8k..8k+7 at 4 bits each, with queue 8k in bits [3:0]. Within a nibble, bit 0 means count == 0, bit 1 means count <= 4, bit 2 means count >= 12, and bit 3 means count == 16.
- R7: A write to a status word changes only the value read back. It changes no count and no data. Any cycle that changes a queue's count reloads all status words from the live flags.
- R8: Sticky words sit at the following addresses, with bit (q mod 32) standing for queue q: 0x420 holds overflow for queues 0-31, 0x424 overflow for 32-63, 0x428 underflow for 0-31, and 0x42C underflow for 32-63. A write stores the written value. A set bit stays set until a 0 is written to it.
- R9: Traffic on one queue leaves the data, counts and flags of every other queue unchanged.
- R10: A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRd |

## Verification
The pop of an entry's last word is the busiest cycle. In that one edge the RAM word is read out, the read pointer and count advance, and every status nibble is reloaded. The bench provokes this on every random pop and on pops that drain a full queue. It judges the cycle by checking that the returned words belong to the pre-pop entry and that the next status read already shows the new count. The second pairing is a shadow write followed by a count change: the bench writes an arbitrary pattern to a status word, reads it back, pushes an entry, and then expects the live flags for all queues to reappear.

// File: rtl/hwQueueMgrPkg.sv
package hwQueueMgrPkg;
  parameter int NUM_Q     = 64;
  parameter int DEPTH     = 16;
  parameter int MAX_WORDS = 4;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 12;
  parameter int NE_LVL    = 4;
  parameter int NF_LVL    = 12;

  localparam int QW     = $clog2(NUM_Q);
  localparam int PW     = $clog2(DEPTH);
  localparam int XW     = $clog2(MAX_WORDS);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int RAM_AW = QW + PW + XW;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] NF_CNT   = CW'(NF_LVL);
  localparam logic [CW-1:0] NE_CNT   = CW'(NE_LVL);

  typedef struct packed {
    logic              ramWe;
    logic              ramRe;
    logic [RAM_AW-1:0] ramWrAddr;
    logic [RAM_AW-1:0] ramRdAddr;
    logic [DATA_W-1:0] ramWrData;
  } qmStrobe_t;

  // nibble: {full, nearly full, nearly empty, empty}
  function automatic logic [3:0] flagsOf(logic [CW-1:0] c);
    return {c == FULL_CNT, c >= NF_CNT, c <= NE_CNT, c == '0};
  endfunction
endpackage

// File: rtl/hwQueueMgrData.sv
module hwQueueMgrData
  import hwQueueMgrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  qmStrobe_t         strobe,
  input  logic [DATA_W-1:0] regQ,
  input  logic              selRam,
  output logic [DATA_W-1:0] rdata
);
  localparam int RAM_WORDS = 2 ** RAM_AW;

  logic [DATA_W-1:0] mem [RAM_WORDS];
  logic [DATA_W-1:0] ramQ;

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[strobe.ramWrAddr] <= strobe.ramWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ramQ <= '0;
    else if (strobe.ramRe) ramQ <= mem[strobe.ramRdAddr];
  end

  assign rdata = selRam ? ramQ : regQ;
endmodule

// File: rtl/hwQueueMgrCtrl.sv
module hwQueueMgrCtrl
  import hwQueueMgrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output qmStrobe_t         strobe,
  output logic [DATA_W-1:0] regQ,
  output logic              selRam
);
  localparam int WIN_TOP = QW + XW + 2;
  localparam int SW      = $clog2(NUM_Q / 8);
  localparam logic [ADDR_W-1:0] STAT_BASE   = ADDR_W'('h400);
  localparam logic [ADDR_W-1:0] STICKY_BASE = ADDR_W'('h420);
  localparam logic [ADDR_W-1:0] CFG_BASE    = ADDR_W'('h500);

  logic [PW-1:0]      wrPtr  [NUM_Q];
  logic [PW-1:0]      rdPtr  [NUM_Q];
  logic [CW-1:0]      cnt    [NUM_Q];
  logic [XW-1:0]      sizeM1 [NUM_Q];
  logic [NUM_Q*4-1:0] shadow;
  logic [NUM_Q*4-1:0] liveNext;
  logic [NUM_Q-1:0]   ovf, udf;

  // address decode
  logic          isWin, isStat, isSticky, isCfg;
  logic [QW-1:0] winQ, cfgQ;
  logic [XW-1:0] winX;
  logic [SW-1:0] statIdx;
  logic [1:0]    stickyIdx;

  assign isWin     = busAddr[ADDR_W-1:WIN_TOP] == '0;
  assign winQ      = busAddr[WIN_TOP-1:XW+2];
  assign winX      = busAddr[XW+1:2];
  assign isStat    = busAddr[ADDR_W-1:SW+2] == STAT_BASE[ADDR_W-1:SW+2];
  assign statIdx   = busAddr[SW+1:2];
  assign isSticky  = busAddr[ADDR_W-1:4] == STICKY_BASE[ADDR_W-1:4];
  assign stickyIdx = busAddr[3:2];
  assign isCfg     = busAddr[ADDR_W-1:QW+2] == CFG_BASE[ADDR_W-1:QW+2];
  assign cfgQ      = busAddr[QW+1:2];

  // queue access qualification
  logic [CW-1:0] curCnt, newCnt;
  logic qFull, qEmpty, wordOk, lastWord;
  logic winWrOk, popReq, pushOk, pushDrop, popOk, popDrop;

  assign curCnt   = cnt[winQ];
  assign qFull    = curCnt == FULL_CNT;
  assign qEmpty   = curCnt == '0;
  assign wordOk   = winX <= sizeM1[winQ];
  assign lastWord = winX == sizeM1[winQ];
  assign winWrOk  = busWr && isWin && wordOk;
  assign popReq   = busRd && isWin && wordOk;
  assign pushOk   = winWrOk && lastWord && !qFull;
  assign pushDrop = winWrOk && lastWord && qFull;
  assign popOk    = popReq && lastWord && !qEmpty;
  assign popDrop  = popReq && lastWord && qEmpty;
  assign newCnt   = pushOk ? curCnt + 1'b1 : curCnt - 1'b1;

  always_comb begin
    strobe.ramWe     = winWrOk && !qFull;
    strobe.ramRe     = popReq && !qEmpty;
    strobe.ramWrAddr = {winQ, wrPtr[winQ], winX};
    strobe.ramRdAddr = {winQ, rdPtr[winQ], winX};
    strobe.ramWrData = busWdata;
  end

  // flags as they stand after this cycle's count update
  always_comb begin
    for (int q = 0; q < NUM_Q; q++) liveNext[q*4 +: 4] = flagsOf(cnt[q]);
    if (pushOk || popOk) liveNext[{winQ, 2'b00} +: 4] = flagsOf(newCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_Q; q++) begin
        wrPtr[q]  <= '0;
        rdPtr[q]  <= '0;
        cnt[q]    <= '0;
        sizeM1[q] <= '0;
        shadow[q*4 +: 4] <= 4'h3;
      end
      ovf    <= '0;
      udf    <= '0;
      regQ   <= '0;
      selRam <= 1'b0;
    end else begin
      if (pushOk) begin
        wrPtr[winQ] <= wrPtr[winQ] + 1'b1;
        cnt[winQ]   <= newCnt;
      end
      if (popOk) begin
        rdPtr[winQ] <= rdPtr[winQ] + 1'b1;
        cnt[winQ]   <= newCnt;
      end
      if (pushOk || popOk) shadow <= liveNext;
      else if (busWr && isStat) shadow[{statIdx, 5'b0} +: 32] <= busWdata;
      if (busWr && isCfg) sizeM1[cfgQ] <= busWdata[XW-1:0];
      if (busWr && isSticky) begin
        case (stickyIdx)
          2'd0:    ovf[31:0]  <= busWdata;
          2'd1:    ovf[63:32] <= busWdata;
          2'd2:    udf[31:0]  <= busWdata;
          default: udf[63:32] <= busWdata;
        endcase
      end
      if (pushDrop) ovf[winQ] <= 1'b1;
      if (popDrop)  udf[winQ] <= 1'b1;
      if (busRd) begin
        selRam <= strobe.ramRe;
        if (isStat) regQ <= shadow[{statIdx, 5'b0} +: 32];
        else if (isSticky) begin
          case (stickyIdx)
            2'd0:    regQ <= ovf[31:0];
            2'd1:    regQ <= ovf[63:32];
            2'd2:    regQ <= udf[31:0];
            default: regQ <= udf[63:32];
          endcase
        end
        else if (isCfg) regQ <= DATA_W'(sizeM1[cfgQ]);
        else regQ <= '0;
      end
    end
  end

  // assertions next to the queue bookkeeping
  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    popOk |=> cnt[$past(winQ)] == $past(curCnt) - 1'b1); // R2
  AST_FULL_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    pushDrop |=> (cnt[$past(winQ)] == FULL_CNT) && ovf[$past(winQ)]); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    curCnt <= FULL_CNT); // R4
  AST_EMPTY_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    popDrop |=> udf[$past(winQ)] && cnt[$past(winQ)] == '0); // R5
  AST_SHADOW_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (pushOk || popOk) |=> shadow[{$past(winQ), 2'b00} +: 4] == flagsOf(cnt[$past(winQ)])); // R7
  AST_STAT_WR_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && isStat) |=> $stable(cnt[0]) && $stable(cnt[NUM_Q-1])); // R7
endmodule

// File: rtl/hwQueueMgr.sv
module hwQueueMgr
  import hwQueueMgrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  qmStrobe_t         strobe;
  logic [DATA_W-1:0] regQ;
  logic              selRam;

  hwQueueMgrCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .strobe(strobe), .regQ(regQ), .selRam(selRam)
  );

  hwQueueMgrData data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regQ(regQ), .selRam(selRam),
    .rdata(busRdata)
  );
endmodule

// File: tb/hwQueueMgr_tb_top.sv
module hwQueueMgr_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int checks = 0, failures = 0;
  logic [127:0] mEnt [64][$];
  int           mSize [64];
  logic [63:0]  mOvf = '0, mUdf = '0;

  hwQueueMgr dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  always #10 clk = ~clk; // 50 MHz

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0; d = busRdata;
  endtask

  function automatic logic [3:0] expFlags(int c);
    return {c == 16, c >= 12, c <= 4, c == 0};
  endfunction

  function automatic logic [31:0] expStat(int k);
    logic [31:0] w;
    for (int j = 0; j < 8; j++) w[j*4 +: 4] = expFlags(mEnt[8*k+j].size());
    return w;
  endfunction

  task automatic setSize(int q, int sz);
    busWrite(12'h500 + 12'(4*q), 32'(sz - 1));
    mSize[q] = sz;
  endtask

  task automatic pushEntry(int q, logic [127:0] d);
    for (int x = 0; x < mSize[q]; x++) busWrite(12'(16*q + 4*x), d[32*x +: 32]);
    if (mEnt[q].size() < 16) mEnt[q].push_back(d);
    else mOvf[q] = 1'b1;
  endtask

  task automatic popEntry(int q, string req);
    logic [31:0]  got;
    logic [127:0] e;
    e = '0;
    if (mEnt[q].size() > 0) e = mEnt[q][0];
    for (int x = 0; x < mSize[q]; x++) begin
      busRead(12'(16*q + 4*x), got);
      check(req, got, e[32*x +: 32]);
    end
    if (mEnt[q].size() > 0) void'(mEnt[q].pop_front());
    else mUdf[q] = 1'b1;
  endtask

  task automatic checkStatus(string req);
    logic [31:0] got;
    for (int k = 0; k < 8; k++) begin
      busRead(12'h400 + 12'(4*k), got);
      check(req, got, expStat(k));
    end
  endtask

  task automatic checkSticky(string req);
    logic [31:0] got;
    busRead(12'h420, got); check(req, got, mOvf[31:0]);
    busRead(12'h424, got); check(req, got, mOvf[63:32]);
    busRead(12'h428, got); check(req, got, mUdf[31:0]);
    busRead(12'h42C, got); check(req, got, mUdf[63:32]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [127:0] d;
    void'($urandom(32'd4242));
    for (int q = 0; q < 64; q++) mSize[q] = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdata", busRdata, 32'h0);
    for (int k = 0; k < 8; k++) begin
      busRead(12'h400 + 12'(4*k), got); check("R1 status", got, 32'h33333333);
    end
    checkSticky("R1 sticky");
    busRead(12'h5FC, got); check("R1 size", got, 32'h0);

    // R3 size config and invalid words
    for (int q = 0; q < 8; q++) setSize(q, (q % 4) + 1);
    setSize(63, 4);
    busRead(12'h50C, got); check("R3 size readback", got, 32'h3);
    setSize(10, 1);
    busWrite(12'(16*10 + 8), 32'hDEAD0001);
    checkStatus("R3 ignored write");
    pushEntry(10, 128'hA5A5_0010);
    busRead(12'(16*10 + 12), got); check("R3 invalid read", got, 32'h0);
    checkStatus("R3 no pop");
    popEntry(10, "R3 entry kept");

    // R2 / R9 ordering across queues
    pushEntry(3, {32'h3333_0004, 32'h3333_0003, 32'h3333_0002, 32'h3333_0001});
    pushEntry(1, {96'h0, 32'h1111_0001});
    pushEntry(3, {32'h3333_0008, 32'h3333_0007, 32'h3333_0006, 32'h3333_0005});
    checkStatus("R6 layout");
    popEntry(3, "R2 order first");
    popEntry(1, "R9 other queue");
    popEntry(3, "R2 order second");

    // R4 fill queue 63 past capacity
    for (int i = 0; i < 17; i++)
      pushEntry(63, {32'(i), 32'hF00D, 32'(i * 3), 32'h6300 + 32'(i)});
    checkStatus("R4/R6 full flags");
    checkSticky("R4 overflow");
    for (int i = 0; i < 16; i++) popEntry(63, "R4 data intact");

    // R5 pop empty
    popEntry(63, "R5 empty returns 0");
    checkSticky("R5 underflow");
    busRead(12'h800, got); check("R10 unmapped", got, 32'h0);

    // random traffic on queues 0..7 and 63
    for (int n = 0; n < 500; n++) begin
      int idx, q;
      idx = $urandom_range(0, 8);
      q = (idx == 8) ? 63 : idx;
      d = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 99) < 55) pushEntry(q, d);
      else popEntry(q, "R2 random pop");
      if (n % 50 == 49) begin
        checkStatus("R6 random status");
        checkSticky("R8 random sticky");
      end
    end

    // R7 shadow write, then reload on count change
    while (mEnt[2].size() >= 16) popEntry(2, "R7 drain");
    busWrite(12'h400, 32'hFFFF_FFFF);
    busRead(12'h400, got); check("R7 shadow readback", got, 32'hFFFF_FFFF);
    busRead(12'h404, got); check("R7 other word", got, expStat(1));
    d = {$urandom, $urandom, $urandom, $urandom};
    pushEntry(2, d);
    checkStatus("R7 reload");
    while (mEnt[2].size() > 0) popEntry(2, "R7 data untouched");

    // R8 sticky write semantics
    busWrite(12'h420, 32'h0);
    mOvf[31:0] = '0;
    busWrite(12'h428, 32'h0000_0100);
    mUdf[31:0] = 32'h0000_0100;
    busWrite(12'h42C, 32'h0);
    mUdf[63:32] = '0;
    checkSticky("R8 write stores");
    popEntry(5, "R8 set again");
    while (mEnt[5].size() > 0) popEntry(5, "R8 set again");
    checkSticky("R8 sticky set");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule